// File: doc/BRIEF.md
# Static Memory Strobe Sequencer

This block times single accesses on an asynchronous 8- or 16-bit memory bus, such as the data bus of a raw NAND device. A client hands over one access at a time through a valid/ready request port, saying read or write and giving the write data. The sequencer then drives an active-low chip select, read strobe and write strobe, plus a per-byte-lane output enable for the data bus. Their shape comes from programmed cycle counts: setup, pulse and total cycle length for writes, and pulse and cycle length for reads.

Chip select stays low for the whole access, with no setup or hold of its own, so it never toggles inside a cycle. The read strobe always asserts in the first cycle of a read. Read data is sampled on the clock edge at which the read strobe is released and returned on a response port. After a read, the device may still be driving the bus, so a programmable turnaround period keeps the sequencer from starting the next access. An optional relaxed mode lets a further read start during that period, because a read never drives the bus. A per-access flag picks full 16-bit width or the low byte lane only.

Top module: `static_strobe_seq`

## Requirements
- R1: After reset, chip select, read strobe and write strobe are high, every output enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: Chip select goes low in the cycle after a request is accepted. It stays low for exactly the access length and then returns high.
- R3: In a write, the write strobe goes low when `cfg_wr_setup` cycles of the access have passed. It stays low for `cfg_wr_pulse` cycles. The access length is `cfg_wr_cycle`, and the read strobe stays high.
- R4: In a read, the read strobe is low from the first access cycle for `cfg_rd_pulse` cycles. The access length is `cfg_rd_cycle`, and the write strobe stays high. The two strobes are never low together.
- R5: If a write's programmed cycle is smaller than setup plus pulse, the access lasts setup+pulse+1 cycles. If a read's cycle is smaller than its pulse, it lasts pulse+1 cycles. A cycle equal to setup plus pulse is not stretched.
- R6: Read data is sampled from `mem_dq_i` on the edge at which the read strobe rises. It appears on `rsp_rdata` with `rsp_valid` high for one cycle, starting in the first cycle the strobe is high.
- R7: The output enables are asserted only while chip select is low in a write. `mem_dq_o` then holds the accepted write data, steady for the whole access.
- R8: After a read access whose latched `cfg_float` is F (F > 0), the sequencer waits F cycles before it accepts a write. It then spends one idle cycle with `req_ready` high, so chip select stays high for F+1 cycles between the two accesses. With F = 0 the gap is one cycle.
- R9: If `cfg_float_skip` was set when the read was accepted, a read request is accepted in the first turnaround cycle, which gives a one-cycle chip-select gap. A write request still waits the full turnaround.
- R10: When `cfg_wide` is low at acceptance, only lane 0 (bits 7:0) is enabled on writes, and `rsp_rdata[15:8]` returns zero on reads. When `cfg_wide` is high, both lanes are used.
- R11: `req_ready` is low while an access is in progress (chip select low), so only one access is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Sequencer takes the request at this edge |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_wdata | input | 16 | Write data |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = low byte lane only |
| cfg_wr_setup | input | 6 | Write strobe setup cycles |
| cfg_wr_pulse | input | 6 | Write strobe low cycles (at least 1) |
| cfg_wr_cycle | input | 6 | Write access length in cycles |
| cfg_rd_pulse | input | 6 | Read strobe low cycles (at least 1) |
| cfg_rd_cycle | input | 6 | Read access length in cycles |
| cfg_float | input | 6 | Turnaround cycles after a read |
| cfg_float_skip | input | 1 | Let a read start during turnaround |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_re_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_o | output | 16 | Data bus out |
| mem_dq_oe | output | 2 | Per-lane data bus output enable |
| mem_dq_i | input | 16 | Data bus in |

## Verification
The assertions assume that both pulse counts are at least one and that every configuration input is steady when a request is accepted. They also assume that `req_valid` and `req_write` hold until acceptance. The stimulus keeps to this: the bench only changes configuration while no request is pending and never programs a zero pulse. It keeps each request stable until it sees `req_ready` at a clock edge. Cycle lengths are chosen with short, equal and stretched cycles, so that the zero-hold and stretching corners are reached without breaking these assumptions.

// File: rtl/smss_pkg.sv
package smss_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACCESS = 2'd1,
      ST_FLOAT  = 2'd2
   } seq_state_t;

   localparam int LANE_BITS = 8;
endpackage

// File: rtl/smss_span.sv
// Access length from a strobe window: stretch when the cycle is too short.
module smss_span #(
   parameter int CW = 6,
   localparam int LW = CW + 1
) (
   input  logic [CW-1:0] setup,
   input  logic [CW-1:0] pulse,
   input  logic [CW-1:0] cycle,
   output logic [LW-1:0] strobe_end,
   output logic [LW-1:0] span
);
   always_comb begin
      strobe_end = {1'b0, setup} + {1'b0, pulse};
      if ({1'b0, cycle} < strobe_end)
         span = strobe_end + LW'(1);
      else
         span = {1'b0, cycle};
   end
endmodule

// File: rtl/smss_ctrl.sv
// Access state machine: cycle counter, strobe window, turnaround period.
module smss_ctrl
   import smss_pkg::*;
#(
   parameter int CW = 6,
   localparam int LW = CW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   output logic          req_ready,
   output logic          accept,
   input  logic [LW-1:0] wr_span,
   input  logic [LW-1:0] wr_end,
   input  logic [CW-1:0] wr_setup,
   input  logic [LW-1:0] rd_span,
   input  logic [LW-1:0] rd_end,
   input  logic [CW-1:0] float_len,
   input  logic          float_skip,
   output logic          cs_n,
   output logic          re_n,
   output logic          we_n,
   output logic          drive,
   output logic          capture
);
   seq_state_t    state;
   logic [LW-1:0] cnt, span_q, start_q, end_q;
   logic [CW-1:0] float_q, fcnt;
   logic          skip_q, op_wr;
   logic          last_cycle, strobe_on;

   assign req_ready  = (state == ST_IDLE) ||
                       (state == ST_FLOAT && skip_q && !req_write);
   assign accept     = req_valid && req_ready;
   assign last_cycle = (cnt == span_q - LW'(1));
   assign strobe_on  = (state == ST_ACCESS) && (cnt >= start_q) && (cnt < end_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         span_q  <= LW'(1);
         start_q <= '0;
         end_q   <= '0;
         float_q <= '0;
         fcnt    <= '0;
         skip_q  <= 1'b0;
         op_wr   <= 1'b0;
      end else if (accept) begin
         state   <= ST_ACCESS;
         cnt     <= '0;
         op_wr   <= req_write;
         span_q  <= req_write ? wr_span : rd_span;
         start_q <= req_write ? {1'b0, wr_setup} : '0;
         end_q   <= req_write ? wr_end : rd_end;
         float_q <= float_len;
         skip_q  <= float_skip;
      end else begin
         unique case (state)
            ST_ACCESS: begin
               if (last_cycle) begin
                  fcnt  <= '0;
                  state <= (!op_wr && float_q != '0) ? ST_FLOAT : ST_IDLE;
               end else begin
                  cnt <= cnt + LW'(1);
               end
            end
            ST_FLOAT: begin
               if (fcnt == float_q - CW'(1)) state <= ST_IDLE;
               else                          fcnt  <= fcnt + CW'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cs_n    = (state != ST_ACCESS);
   assign we_n    = !(strobe_on && op_wr);
   assign re_n    = !(strobe_on && !op_wr);
   assign drive   = (state == ST_ACCESS) && op_wr;
   assign capture = (state == ST_ACCESS) && !op_wr && (cnt == end_q - LW'(1));

   AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n || !re_n) |-> !cs_n);                                    // R2
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n));                                             // R4
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> !req_ready);                                          // R11
   AST_FLOAT_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FLOAT && accept) |=> (!op_wr && !cs_n));           // R9
   AST_SPAN_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACCESS && last_cycle) |-> (cnt + LW'(1) >= end_q)); // R5
   AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACCESS && !last_cycle) |=> !cs_n);                 // R2
endmodule

// File: rtl/smss_lane.sv
// One byte lane of the data bus: write hold register, enable, read capture.
module smss_lane
   import smss_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 accept,
   input  logic                 lane_on,
   input  logic [LANE_BITS-1:0] wbyte,
   input  logic                 drive,
   input  logic                 capture,
   input  logic [LANE_BITS-1:0] din,
   output logic [LANE_BITS-1:0] dout,
   output logic                 oe,
   output logic [LANE_BITS-1:0] rbyte
);
   logic [LANE_BITS-1:0] wd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_q  <= '0;
         rbyte <= '0;
      end else begin
         if (accept)  wd_q  <= wbyte;
         if (capture) rbyte <= lane_on ? din : '0;
      end
   end

   assign dout = wd_q;
   assign oe   = drive && lane_on;

   AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (oe && $past(oe)) |-> $stable(dout));                           // R7
endmodule

// File: rtl/static_strobe_seq.sv
module static_strobe_seq
   import smss_pkg::*;
#(
   parameter int LANES = 2,
   parameter int CW    = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic                   req_write,
   input  logic [8*LANES-1:0]     req_wdata,
   input  logic                   cfg_wide,
   input  logic [CW-1:0]          cfg_wr_setup,
   input  logic [CW-1:0]          cfg_wr_pulse,
   input  logic [CW-1:0]          cfg_wr_cycle,
   input  logic [CW-1:0]          cfg_rd_pulse,
   input  logic [CW-1:0]          cfg_rd_cycle,
   input  logic [CW-1:0]          cfg_float,
   input  logic                   cfg_float_skip,
   output logic                   rsp_valid,
   output logic [8*LANES-1:0]     rsp_rdata,
   output logic                   mem_cs_n,
   output logic                   mem_re_n,
   output logic                   mem_we_n,
   output logic [8*LANES-1:0]     mem_dq_o,
   output logic [LANES-1:0]       mem_dq_oe,
   input  logic [8*LANES-1:0]     mem_dq_i
);
   localparam int LW = CW + 1;

   if (LANES < 1 || LANES > 2) begin : g_bad_lanes
      $error("static_strobe_seq: LANES must be 1 or 2");
   end
   if (CW < 2) begin : g_bad_cw
      $error("static_strobe_seq: CW must be at least 2");
   end

   logic [LW-1:0] wr_span, wr_end, rd_span, rd_end;
   logic          accept, drive, capture, wide_q;
   logic [LANES-1:0][LANE_BITS-1:0] dout_a, rbyte_a;

   smss_span #(.CW(CW)) u_wr_span (
      .setup(cfg_wr_setup), .pulse(cfg_wr_pulse), .cycle(cfg_wr_cycle),
      .strobe_end(wr_end), .span(wr_span));

   smss_span #(.CW(CW)) u_rd_span (
      .setup('0), .pulse(cfg_rd_pulse), .cycle(cfg_rd_cycle),
      .strobe_end(rd_end), .span(rd_span));

   smss_ctrl #(.CW(CW)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write),
      .req_ready(req_ready), .accept(accept),
      .wr_span(wr_span), .wr_end(wr_end), .wr_setup(cfg_wr_setup),
      .rd_span(rd_span), .rd_end(rd_end),
      .float_len(cfg_float), .float_skip(cfg_float_skip),
      .cs_n(mem_cs_n), .re_n(mem_re_n), .we_n(mem_we_n),
      .drive(drive), .capture(capture));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wide_q    <= 1'b0;
         rsp_valid <= 1'b0;
      end else begin
         if (accept) wide_q <= cfg_wide;
         rsp_valid <= capture;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic lane_on;
      if (g == 0) begin : g_base
         assign lane_on = 1'b1;
      end else begin : g_upper
         assign lane_on = wide_q;
      end
      smss_lane u_lane (
         .clk(clk), .rst_n(rst_n), .accept(accept), .lane_on(lane_on),
         .wbyte(req_wdata[g*LANE_BITS +: LANE_BITS]),
         .drive(drive), .capture(capture),
         .din(mem_dq_i[g*LANE_BITS +: LANE_BITS]),
         .dout(dout_a[g]), .oe(mem_dq_oe[g]), .rbyte(rbyte_a[g]));
   end

   assign mem_dq_o  = dout_a;
   assign rsp_rdata = rbyte_a;

   AST_RSP_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $rose(mem_re_n));                                 // R6
   AST_OE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe != '0) |-> (!mem_cs_n && mem_re_n));                 // R7
   if (LANES == 2) begin : g_narrow_chk
      AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
         (!wide_q && (rsp_valid || mem_dq_oe != '0))
            |-> (!mem_dq_oe[1] && (!rsp_valid || rsp_rdata[15:8] == 8'h00))); // R10
   end
endmodule

// File: tb/tb_static_strobe_seq.sv
`timescale 1ns/100ps
module tb_static_strobe_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [15:0] req_wdata = '0;
   logic        req_ready;
   logic        cfg_wide = 1'b1, cfg_float_skip = 1'b0;
   logic [5:0]  cfg_wr_setup = 6'd1, cfg_wr_pulse = 6'd1, cfg_wr_cycle = 6'd2;
   logic [5:0]  cfg_rd_pulse = 6'd1, cfg_rd_cycle = 6'd2, cfg_float = 6'd0;
   logic        rsp_valid, mem_cs_n, mem_re_n, mem_we_n;
   logic [15:0] rsp_rdata, mem_dq_o, mem_dq_i = '0;
   logic [1:0]  mem_dq_oe;

   int checks = 0, errors = 0;
   int run = 0, last_gap = 0;
   logic [15:0] exp_q[$];

   always #2.5 clk = ~clk;

   static_strobe_seq dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_wdata(req_wdata), .cfg_wide(cfg_wide),
      .cfg_wr_setup(cfg_wr_setup), .cfg_wr_pulse(cfg_wr_pulse),
      .cfg_wr_cycle(cfg_wr_cycle), .cfg_rd_pulse(cfg_rd_pulse),
      .cfg_rd_cycle(cfg_rd_cycle), .cfg_float(cfg_float),
      .cfg_float_skip(cfg_float_skip), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n), .mem_re_n(mem_re_n),
      .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
      .mem_dq_i(mem_dq_i));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Monitor: pops expected read data as responses appear (R6, R10).
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) chk(1'b0, "R6 unexpected response", rsp_rdata, 0);
         else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk(rsp_rdata == e, "R6/R10 read data", rsp_rdata, e);
         end
      end
   end

   // Chip-select idle gap between consecutive accesses (R8, R9).
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_cs_n) run++;
         else if (run > 0) begin
            last_gap = run;
            run = 0;
         end
      end
   end

   // Present a request; returns at the negedge of the first access cycle.
   task automatic issue(input bit wr, input logic [15:0] d);
      req_write = wr;
      req_wdata = d;
      req_valid = 1'b1;
      #0.5;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_write(input int s, input int p, input int c, input bit wide,
                           input logic [15:0] d);
      int span, k, first_we, we_cnt, re_cnt, oe_bad;
      logic [15:0] mask, seen;
      logic [1:0] oe_exp;
      span = (c < s + p) ? s + p + 1 : c;
      mask = wide ? 16'hFFFF : 16'h00FF;
      oe_exp = wide ? 2'b11 : 2'b01;
      cfg_wr_setup = 6'(s); cfg_wr_pulse = 6'(p); cfg_wr_cycle = 6'(c);
      cfg_wide = wide;
      issue(1'b1, d);
      k = 0; first_we = -1; we_cnt = 0; re_cnt = 0; oe_bad = 0; seen = '0;
      while (!mem_cs_n && k < 300) begin
         if (!mem_we_n) begin
            if (first_we < 0) first_we = k;
            we_cnt++;
            seen = mem_dq_o & mask;
         end
         if (!mem_re_n) re_cnt++;
         if (mem_dq_oe != oe_exp) oe_bad++;
         k++;
         @(negedge clk);
      end
      chk(k == span, "R2/R3/R5 write cs length", k, span);
      chk(first_we == s, "R3 write strobe start", first_we, s);
      chk(we_cnt == p, "R3 write strobe width", we_cnt, p);
      chk(re_cnt == 0, "R4 no read strobe in write", re_cnt, 0);
      chk(oe_bad == 0, wide ? "R7 output enable" : "R10 narrow output enable",
          oe_bad, 0);
      chk(seen == (d & mask), "R7 write data on bus", seen, d & mask);
      chk(mem_dq_oe == 2'b00, "R7 enable off after write", mem_dq_oe, 0);
   endtask

   task automatic do_read(input int p, input int c, input int fl, input bit skip,
                          input bit wide, input logic [15:0] pins);
      int span, k, re_first, re_cnt, we_cnt, rsp_at, ready_hi;
      span = (c < p) ? p + 1 : c;
      cfg_rd_pulse = 6'(p); cfg_rd_cycle = 6'(c);
      cfg_float = 6'(fl); cfg_float_skip = skip; cfg_wide = wide;
      mem_dq_i = pins;
      exp_q.push_back(wide ? pins : {8'h00, pins[7:0]});
      issue(1'b0, 16'h0000);
      k = 0; re_first = -1; re_cnt = 0; we_cnt = 0; rsp_at = -1; ready_hi = 0;
      while (!mem_cs_n && k < 300) begin
         if (!mem_re_n) begin
            if (re_first < 0) re_first = k;
            re_cnt++;
         end
         if (!mem_we_n) we_cnt++;
         if (rsp_valid && rsp_at < 0) rsp_at = k;
         if (req_ready) ready_hi++;
         k++;
         @(negedge clk);
      end
      chk(k == span, "R2/R4/R5 read cs length", k, span);
      chk(re_first == 0, "R4 read strobe in first cycle", re_first, 0);
      chk(re_cnt == p, "R4 read strobe width", re_cnt, p);
      chk(we_cnt == 0, "R4 no write strobe in read", we_cnt, 0);
      chk(rsp_at == p, "R6 response timing", rsp_at, p);
      chk(ready_hi == 0, "R11 ready low during access", ready_hi, 0);
   endtask

   initial begin
      #(5.0 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk({mem_cs_n, mem_re_n, mem_we_n} == 3'b111, "R1 strobes idle in reset",
          {mem_cs_n, mem_re_n, mem_we_n}, 3'b111);
      rst_n = 1'b1;
      @(negedge clk);
      chk({mem_cs_n, mem_re_n, mem_we_n} == 3'b111, "R1 strobes idle",
          {mem_cs_n, mem_re_n, mem_we_n}, 3'b111);
      chk(mem_dq_oe == 2'b00, "R1 enables off", mem_dq_oe, 0);
      chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
      chk(rsp_valid == 1'b0, "R1 no response", rsp_valid, 0);
      repeat (2) @(negedge clk);

      do_write(2, 3, 8, 1'b1, 16'hBEEF);          // R3 plain
      do_write(0, 2, 3, 1'b1, 16'h1234);          // R3 zero setup
      do_write(3, 4, 5, 1'b1, 16'hC0DE);          // R5 stretched
      do_write(1, 1, 2, 1'b1, 16'h0F0F);          // R5 equal, not stretched
      do_write(2, 2, 6, 1'b0, 16'hA55A);          // R10 narrow write

      do_read(3, 6, 0, 1'b0, 1'b1, 16'h3C96);     // R4, R6
      do_read(4, 2, 0, 1'b0, 1'b1, 16'h7E81);     // R5 read stretch
      do_read(2, 4, 0, 1'b0, 1'b0, 16'hD2B4);     // R10 narrow read
      do_write(1, 2, 4, 1'b1, 16'h5555);
      chk(last_gap == 1, "R8 zero turnaround gap", last_gap, 1);

      do_read(2, 3, 3, 1'b0, 1'b1, 16'h1111);
      do_write(1, 2, 4, 1'b1, 16'h2222);
      chk(last_gap == 4, "R8 turnaround before write", last_gap, 4);

      do_read(2, 3, 3, 1'b0, 1'b1, 16'h3333);
      do_read(2, 3, 0, 1'b0, 1'b1, 16'h4444);
      chk(last_gap == 4, "R8 turnaround read-read without skip", last_gap, 4);

      do_read(2, 3, 3, 1'b1, 1'b1, 16'h5A5A);
      do_read(2, 3, 0, 1'b0, 1'b1, 16'h6B6B);
      chk(last_gap == 1, "R9 skip lets read start early", last_gap, 1);

      do_read(2, 3, 5, 1'b1, 1'b1, 16'h7C7C);
      do_write(0, 1, 2, 1'b1, 16'h8D8D);
      chk(last_gap == 6, "R9 skip still delays write", last_gap, 6);

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R6 all responses seen", exp_q.size(), 0);
      chk(req_ready == 1'b1, "R11 ready back when idle", req_ready, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule